// File: doc/BRIEF.md
# Miss Tracking Entry with Deferred Target Queue

This block is a single entry of a cache's outstanding-miss tracker. Once allocated for a missing line it records every request waiting on that line as a target descriptor: source agent, operation code, a needs-writable bit, a marked-pending bit and an order id. Requests that can be satisfied by the fill in flight go to the primary queue. Requests that must wait for a later, stronger fill go to the deferred queue. The cache controller drives one-cycle command strobes: allocate, add, start service, pop, promote, rewrite upgrades, delay and deallocate. It reads the head of the primary queue, the total target count and the coherence status flags.

Promotion moves deferred targets to the primary queue one per cycle, in order. It stops at the first target that needs a writable copy or is a cache-maintenance operation. A busy flag stays high while promotion runs, and pops and adds are refused during that time. The entry also computes which primary targets a read response carrying an unexpected invalidate may serve. It keeps a ready time that a delay command can push forward.

Top module: `mshr_entry`

## Requirements
- R1: After reset or a deallocate strobe, the entry is invalid and both queues are empty. The in-service bit, the busy flag and all status flags are zero, and the ready time is zero.
- R2: Allocate on a free entry makes it valid, stores the supplied target as the only primary target (marked-pending 0) and loads the ready time with `now_i`. Allocate on a valid entry has no effect.
- R3: Add stores the target at the tail of the primary queue, or of the deferred queue when `add_defer_i` is 1. If the selected queue already holds DEPTH targets, `stall_o` is high in that cycle and the target is not stored. A stall on one queue does not block adds to the other.
- R4: `num_targets_o` equals the primary plus the deferred occupancy. `has_targets_o` is 1 exactly when the primary queue is non-empty.
- R5: Marked-pending is 1 for a target added to the primary queue while the entry is in service. It is also 1 for every primary target when the entry enters service and for every promoted target. It is 0 for a deferred add and for a primary add outside service.
- R6: A service strobe sets the in-service bit and latches `pend_mod_i` as pending-modified. In service, `snoop_inv_i` sets post-invalidate and `snoop_rd_i` sets post-downgrade. The three flag outputs are 0 whenever the entry is not in service, and raising `stat_rd_i` outside service is an assertion error.
- R7: A promote strobe raises `promo_busy_o` in the next cycle. Each busy cycle moves at most one deferred head to the primary tail. Busy drops the cycle after the deferred queue is empty, the primary queue is full, or the deferred head blocks. A head blocks if it has needs-writable set or op code 5 (maintenance). The total count is unchanged throughout.
- R8: While `promo_busy_o` is 1, pop is ignored and add raises `stall_o` without storing.
- R9: Rewrite changes op code 2 (upgrade) to 1 (read-exclusive) and op code 3 (store-conditional) to 4 (failed store-conditional) in every held target of both queues. Other codes are unchanged.
- R10: Bit i of `serviceable_o` is 1 exactly when primary position i (0 = head) holds a target and it is either from source 1 (snoop) or the first target from source 0 (CPU). Source 2 is prefetcher.
- R11: A delay strobe, legal only when the ready time is not later than `now_i`, sets the ready time to `now_i + delay_amt_i`.
- R12: Pop removes the primary head. A pop and an add to the primary queue in the same cycle keep the count unchanged and advance the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_i | input | 1 | Allocate strobe |
| add_i | input | 1 | Add-target strobe |
| add_defer_i | input | 1 | Add to deferred queue instead of primary |
| tgt_src_i | input | 2 | Target source (0 CPU, 1 snoop, 2 prefetcher) |
| tgt_op_i | input | 3 | Target op code |
| tgt_needs_wr_i | input | 1 | Target needs a writable copy |
| tgt_order_i | input | 8 | Target order id |
| service_i | input | 1 | Enter-service strobe |
| pend_mod_i | input | 1 | Pending-modified value latched on service |
| snoop_inv_i | input | 1 | Invalidating snoop seen |
| snoop_rd_i | input | 1 | Reading snoop seen |
| stat_rd_i | input | 1 | Consumer reads status flags this cycle |
| pop_i | input | 1 | Pop primary head |
| promote_i | input | 1 | Start promotion |
| rewrite_i | input | 1 | Rewrite upgrades |
| delay_i | input | 1 | Delay strobe |
| delay_amt_i | input | 8 | Delay amount in cycles |
| now_i | input | 16 | Current cycle number |
| dealloc_i | input | 1 | Deallocate strobe |
| valid_o | output | 1 | Entry allocated |
| in_service_o | output | 1 | Entry in service |
| promo_busy_o | output | 1 | Promotion running |
| stall_o | output | 1 | Add refused this cycle |
| has_targets_o | output | 1 | Primary queue non-empty |
| num_targets_o | output | 5 | Total held targets |
| head_src_o | output | 2 | Primary head source |
| head_op_o | output | 3 | Primary head op code |
| head_needs_wr_o | output | 1 | Primary head needs-writable |
| head_marked_o | output | 1 | Primary head marked-pending |
| head_order_o | output | 8 | Primary head order id |
| serviceable_o | output | 8 | Primary positions serviceable by an invalidating read response |
| pending_mod_o | output | 1 | Pending-modified (0 outside service) |
| post_inv_o | output | 1 | Post-invalidate (0 outside service) |
| post_dg_o | output | 1 | Post-downgrade (0 outside service) |
| ready_time_o | output | 16 | Ready time |

## Verification
A pop and an add on the primary queue can fall in the same cycle. The bench drives both strobes together on a partly filled queue. It judges the result by an unchanged total count and a head that moved to the next order id. The other collision is a pop or add that lands while promotion is moving targets. That case is provoked in the first busy cycle after a promote strobe, with `stall_o` checked before the edge. It is judged afterwards by the same count, the same head, and a busy window of exactly one cycle per moved target plus one.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  localparam int ORDER_W = 8;

  typedef enum logic [1:0] {SRC_CPU = 2'd0, SRC_SNOOP = 2'd1, SRC_PREF = 2'd2} src_e;

  typedef enum logic [2:0] {
    OP_RD = 3'd0, OP_RDEX = 3'd1, OP_UPG = 3'd2, OP_SC = 3'd3,
    OP_SCFAIL = 3'd4, OP_MAINT = 3'd5, OP_WR = 3'd6
  } op_e;

  typedef struct packed {
    src_e               src;
    op_e                op;
    logic               needs_wr;
    logic               marked;
    logic [ORDER_W-1:0] order;
  } tgt_t;

  // a deferred head that stops promotion
  function automatic logic blocks_promotion(tgt_t t);
    return t.needs_wr || (t.op == OP_MAINT);
  endfunction

  // upgrade becomes read-exclusive, store-conditional becomes a failure
  function automatic op_e rewrite_op(op_e op);
    case (op)
      OP_UPG:  return OP_RDEX;
      OP_SC:   return OP_SCFAIL;
      default: return op;
    endcase
  endfunction
endpackage

// File: rtl/mshr_tgt_fifo.sv
module mshr_tgt_fifo
  import mshr_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  push_i,
  input  tgt_t                  push_data_i,
  input  logic                  pop_i,
  input  logic                  rewrite_i,
  input  logic                  mark_all_i,
  output tgt_t                  head_o,
  output logic [CW-1:0]         count_o,
  output logic                  full_o,
  output logic                  empty_o,
  output tgt_t [DEPTH-1:0]      view_o
);
  tgt_t          mem [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (clr_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        if (rewrite_i)  mem[k].op     <= rewrite_op(mem[k].op);
        if (mark_all_i) mem[k].marked <= 1'b1;
      end
      if (push_i) begin
        mem[wr_q] <= push_data_i;
        wr_q      <= wr_q + AW'(1);
      end
      if (pop_i) rd_q <= rd_q + AW'(1);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign head_o  = mem[rd_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);

  // ordered view, position 0 is the head
  for (genvar i = 0; i < DEPTH; i++) begin : g_view
    logic [AW-1:0] slot;
    assign slot      = rd_q + AW'(i);
    assign view_o[i] = mem[slot];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !clr_i) |-> !full_o); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !clr_i) |-> !empty_o); // R12
endmodule

// File: rtl/mshr_ready_timer.sv
module mshr_ready_timer #(
  parameter int TIME_W = 16,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic              delay_i,
  input  logic [DLY_W-1:0]  delay_amt_i,
  input  logic [TIME_W-1:0] now_i,
  output logic [TIME_W-1:0] ready_time_o
);
  logic [TIME_W-1:0] ready_q;

  function automatic logic [TIME_W-1:0] push_out(logic [TIME_W-1:0] now, logic [DLY_W-1:0] amt);
    return now + TIME_W'(amt);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ready_q <= '0;
    else if (clr_i)   ready_q <= '0;
    else if (load_i)  ready_q <= now_i;
    else if (delay_i) ready_q <= push_out(now_i, delay_amt_i);
  end

  assign ready_time_o = ready_q;

  AST_DELAY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    delay_i |-> (ready_q <= now_i)); // R11
endmodule

// File: rtl/mshr_entry.sv
module mshr_entry
  import mshr_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TIME_W = 16,
  parameter int DLY_W  = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1,
  localparam int NW = CW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_i,
  input  logic               add_i,
  input  logic               add_defer_i,
  input  logic [1:0]         tgt_src_i,
  input  logic [2:0]         tgt_op_i,
  input  logic               tgt_needs_wr_i,
  input  logic [ORDER_W-1:0] tgt_order_i,
  input  logic               service_i,
  input  logic               pend_mod_i,
  input  logic               snoop_inv_i,
  input  logic               snoop_rd_i,
  input  logic               stat_rd_i,
  input  logic               pop_i,
  input  logic               promote_i,
  input  logic               rewrite_i,
  input  logic               delay_i,
  input  logic [DLY_W-1:0]   delay_amt_i,
  input  logic [TIME_W-1:0]  now_i,
  input  logic               dealloc_i,
  output logic               valid_o,
  output logic               in_service_o,
  output logic               promo_busy_o,
  output logic               stall_o,
  output logic               has_targets_o,
  output logic [NW-1:0]      num_targets_o,
  output logic [1:0]         head_src_o,
  output logic [2:0]         head_op_o,
  output logic               head_needs_wr_o,
  output logic               head_marked_o,
  output logic [ORDER_W-1:0] head_order_o,
  output logic [DEPTH-1:0]   serviceable_o,
  output logic               pending_mod_o,
  output logic               post_inv_o,
  output logic               post_dg_o,
  output logic [TIME_W-1:0]  ready_time_o
);
  logic valid_q, in_svc_q, pend_q, post_inv_q, post_dg_q, busy_q;

  tgt_t             pri_head, def_head, new_tgt, promoted, pri_data;
  tgt_t [DEPTH-1:0] pri_view, def_view;
  logic [CW-1:0]    pri_cnt, def_cnt;
  logic             pri_full, pri_empty, def_full, def_empty;

  // named events for the assertions
  logic alloc_go, add_go, sel_full, pop_go, svc_go, promo_start, promo_move;
  logic rw_go, dly_go, pri_push, def_push;

  function automatic logic [DEPTH-1:0] service_mask(tgt_t [DEPTH-1:0] v, logic [CW-1:0] n);
    logic [DEPTH-1:0] m;
    logic             seen_cpu;
    m        = '0;
    seen_cpu = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i) < n) begin
        if (v[i].src == SRC_SNOOP) m[i] = 1'b1;
        else if (v[i].src == SRC_CPU && !seen_cpu) begin
          m[i]     = 1'b1;
          seen_cpu = 1'b1;
        end
      end
    end
    return m;
  endfunction

  function automatic logic any_marked(tgt_t [DEPTH-1:0] v, logic [CW-1:0] n);
    logic r;
    r = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (CW'(i) < n && v[i].marked) r = 1'b1;
    return r;
  endfunction

  assign sel_full    = add_defer_i ? def_full : pri_full;
  assign alloc_go    = alloc_i && !valid_q && !dealloc_i;
  assign add_go      = add_i && valid_q && !busy_q && !sel_full && !dealloc_i;
  assign stall_o     = add_i && valid_q && (busy_q || sel_full);
  assign pop_go      = pop_i && valid_q && !busy_q && !pri_empty && !dealloc_i;
  assign svc_go      = service_i && valid_q && !in_svc_q && !dealloc_i;
  assign promo_start = promote_i && valid_q && !busy_q && !dealloc_i;
  assign promo_move  = busy_q && !def_empty && !blocks_promotion(def_head) && !pri_full && !dealloc_i;
  assign rw_go       = rewrite_i && valid_q && !dealloc_i;
  assign dly_go      = delay_i && valid_q && !dealloc_i;

  always_comb begin
    new_tgt.src      = src_e'(tgt_src_i);
    new_tgt.op       = op_e'(tgt_op_i);
    new_tgt.needs_wr = tgt_needs_wr_i;
    new_tgt.marked   = 1'b0;
    new_tgt.order    = tgt_order_i;
    promoted         = def_head;
    promoted.marked  = 1'b1;
    if (rw_go) promoted.op = rewrite_op(def_head.op);
    if (promo_move) pri_data = promoted;
    else begin
      pri_data        = new_tgt;
      pri_data.marked = in_svc_q || svc_go;
    end
  end

  assign pri_push = alloc_go || (add_go && !add_defer_i) || promo_move;
  assign def_push = add_go && add_defer_i;

  mshr_tgt_fifo #(.DEPTH(DEPTH)) u_pri (
    .clk, .rst_n, .clr_i(dealloc_i), .push_i(pri_push), .push_data_i(pri_data),
    .pop_i(pop_go), .rewrite_i(rw_go), .mark_all_i(svc_go), .head_o(pri_head),
    .count_o(pri_cnt), .full_o(pri_full), .empty_o(pri_empty), .view_o(pri_view)
  );

  mshr_tgt_fifo #(.DEPTH(DEPTH)) u_def (
    .clk, .rst_n, .clr_i(dealloc_i), .push_i(def_push), .push_data_i(new_tgt),
    .pop_i(promo_move), .rewrite_i(rw_go), .mark_all_i(1'b0), .head_o(def_head),
    .count_o(def_cnt), .full_o(def_full), .empty_o(def_empty), .view_o(def_view)
  );

  mshr_ready_timer #(.TIME_W(TIME_W), .DLY_W(DLY_W)) u_timer (
    .clk, .rst_n, .clr_i(dealloc_i), .load_i(alloc_go), .delay_i(dly_go),
    .delay_amt_i, .now_i, .ready_time_o
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || dealloc_i) begin
      valid_q    <= 1'b0;
      in_svc_q   <= 1'b0;
      pend_q     <= 1'b0;
      post_inv_q <= 1'b0;
      post_dg_q  <= 1'b0;
      busy_q     <= 1'b0;
    end else begin
      if (alloc_go) valid_q <= 1'b1;
      if (svc_go) begin
        in_svc_q   <= 1'b1;
        pend_q     <= pend_mod_i;
        post_inv_q <= 1'b0;
        post_dg_q  <= 1'b0;
      end
      if (in_svc_q && snoop_inv_i) post_inv_q <= 1'b1;
      if (in_svc_q && snoop_rd_i)  post_dg_q  <= 1'b1;
      busy_q <= busy_q ? promo_move : promo_start;
    end
  end

  assign valid_o         = valid_q;
  assign in_service_o    = in_svc_q;
  assign promo_busy_o    = busy_q;
  assign has_targets_o   = !pri_empty;
  assign num_targets_o   = NW'(pri_cnt) + NW'(def_cnt);
  assign head_src_o      = pri_head.src;
  assign head_op_o       = pri_head.op;
  assign head_needs_wr_o = pri_head.needs_wr;
  assign head_marked_o   = pri_head.marked;
  assign head_order_o    = pri_head.order;
  assign serviceable_o   = service_mask(pri_view, pri_cnt);
  assign pending_mod_o   = in_svc_q && pend_q;
  assign post_inv_o      = in_svc_q && post_inv_q;
  assign post_dg_o       = in_svc_q && post_dg_q;

  AST_DEALLOC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dealloc_i |=> (!valid_o && num_targets_o == '0 && !in_service_o && !promo_busy_o)); // R1
  AST_HAS_TARGETS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    has_targets_o |-> (num_targets_o != '0)); // R4
  AST_DEFERRED_UNMARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !any_marked(def_view, def_cnt)); // R5
  AST_STATUS_READ_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_i |-> in_service_o); // R6
  AST_PROMO_KEEPS_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !dealloc_i) |=> $stable(num_targets_o)); // R7
  AST_STALL_STORES_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && !pop_go && !promo_move && !dealloc_i) |=> $stable(num_targets_o)); // R3
endmodule

// File: tb/tb_mshr_entry.sv
module tb_mshr_entry;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic alloc_i = 0, add_i = 0, add_defer_i = 0, service_i = 0, pend_mod_i = 0;
  logic snoop_inv_i = 0, snoop_rd_i = 0, stat_rd_i = 0, pop_i = 0, promote_i = 0;
  logic rewrite_i = 0, delay_i = 0, dealloc_i = 0, tgt_needs_wr_i = 0;
  logic [1:0]  tgt_src_i = 0;
  logic [2:0]  tgt_op_i = 0;
  logic [7:0]  tgt_order_i = 0, delay_amt_i = 0;
  logic [15:0] now_i;
  logic valid_o, in_service_o, promo_busy_o, stall_o, has_targets_o;
  logic [4:0]  num_targets_o;
  logic [1:0]  head_src_o;
  logic [2:0]  head_op_o;
  logic        head_needs_wr_o, head_marked_o;
  logic [7:0]  head_order_o, serviceable_o;
  logic        pending_mod_o, post_inv_o, post_dg_o;
  logic [15:0] ready_time_o;

  int cyc = 0;
  int nchk = 0;
  int nerr = 0;
  always @(posedge clk) cyc <= cyc + 1;
  assign now_i = cyc[15:0];

  mshr_entry dut (.*);

  always @(posedge clk) if (cyc > 20000) begin
    nerr++; nchk++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    alloc_i = 0; add_i = 0; add_defer_i = 0; service_i = 0; pend_mod_i = 0;
    snoop_inv_i = 0; snoop_rd_i = 0; stat_rd_i = 0; pop_i = 0; promote_i = 0;
    rewrite_i = 0; delay_i = 0; dealloc_i = 0;
  endtask

  task automatic set_tgt(int src, int op, bit nw, int order);
    tgt_src_i = 2'(src); tgt_op_i = 3'(op); tgt_needs_wr_i = nw; tgt_order_i = 8'(order);
  endtask

  task automatic do_alloc(int src, int op, bit nw, int order);
    set_tgt(src, op, nw, order); alloc_i = 1; tick();
  endtask

  task automatic do_add(bit defer, int src, int op, bit nw, int order);
    set_tgt(src, op, nw, order); add_i = 1; add_defer_i = defer; tick();
  endtask

  task automatic pop_expect(string tag, int order, int op, int marked);
    chk({tag, " head order"}, head_order_o, order);
    chk({tag, " head op"}, head_op_o, op);
    chk({tag, " head marked"}, head_marked_o, marked);
    pop_i = 1; tick();
  endtask

  task automatic wait_promo(output int busy_cycles);
    busy_cycles = 0;
    while (promo_busy_o && busy_cycles < 20) begin busy_cycles++; tick(); end
  endtask

  task automatic t_reset();
    chk("R1 valid after reset", valid_o, 0);
    chk("R1 count after reset", num_targets_o, 0);
    chk("R1 has_targets after reset", has_targets_o, 0);
    chk("R1 in_service after reset", in_service_o, 0);
    chk("R1 busy after reset", promo_busy_o, 0);
    chk("R1 ready time after reset", ready_time_o, 0);
  endtask

  task automatic t_main_flow();
    int exp_rt, bc;
    exp_rt = cyc;
    do_alloc(0, 0, 0, 1);
    chk("R2 valid", valid_o, 1);
    chk("R2 count", num_targets_o, 1);
    chk("R2 head order", head_order_o, 1);
    chk("R2 head unmarked", head_marked_o, 0);
    chk("R2 ready time", ready_time_o, exp_rt);
    do_alloc(0, 0, 0, 9);
    chk("R2 realloc ignored count", num_targets_o, 1);
    chk("R2 realloc ignored head", head_order_o, 1);
    do_add(0, 0, 0, 0, 2);
    do_add(0, 0, 0, 0, 3);
    do_add(1, 0, 0, 0, 10);
    do_add(1, 0, 0, 0, 11);
    do_add(1, 0, 0, 1, 12);
    do_add(1, 0, 0, 0, 13);
    chk("R4 total count", num_targets_o, 7);
    chk("R4 has_targets", has_targets_o, 1);
    promote_i = 1; tick();
    chk("R7 busy after promote", promo_busy_o, 1);
    pop_i = 1; add_i = 1; set_tgt(0, 0, 0, 50); #1;
    chk("R8 add stalls while busy", stall_o, 1);
    tick();
    wait_promo(bc);
    chk("R7 busy cycles (2 moves + stop)", bc + 1, 3);
    chk("R8 count unchanged by blocked pop/add", num_targets_o, 7);
    pop_expect("R8 head kept / R12 pop", 1, 0, 0);
    chk("R12 count after pop", num_targets_o, 6);
    service_i = 1; pend_mod_i = 1; tick();
    chk("R6 in_service", in_service_o, 1);
    chk("R6 pending_mod", pending_mod_o, 1);
    chk("R6 post_inv clear", post_inv_o, 0);
    chk("R6 post_dg clear", post_dg_o, 0);
    pop_expect("R5 marked on service", 2, 0, 1);
    pop_expect("R5 marked on service", 3, 0, 1);
    pop_expect("R5 marked on promote", 10, 0, 1);
    pop_expect("R7 in-order promote", 11, 0, 1);
    chk("R4 primary empty", has_targets_o, 0);
    chk("R4 count keeps deferred", num_targets_o, 2);
    do_add(0, 1, 0, 0, 4);
    chk("R5 add in service marked", head_marked_o, 1);
    snoop_inv_i = 1; stat_rd_i = 1; tick();
    chk("R6 post_inv set", post_inv_o, 1);
    chk("R6 post_dg not set", post_dg_o, 0);
    snoop_rd_i = 1; tick();
    chk("R6 post_dg set", post_dg_o, 1);
    exp_rt = cyc + 5;
    delay_i = 1; delay_amt_i = 5; tick();
    chk("R11 delayed ready time", ready_time_o, exp_rt);
    dealloc_i = 1; tick();
    chk("R1 valid after dealloc", valid_o, 0);
    chk("R1 count after dealloc", num_targets_o, 0);
    chk("R1 in_service after dealloc", in_service_o, 0);
    chk("R6 pending_mod gated", pending_mod_o, 0);
    chk("R6 post_inv gated", post_inv_o, 0);
    chk("R1 ready time after dealloc", ready_time_o, 0);
  endtask

  task automatic t_rewrite_promote();
    int bc;
    do_alloc(0, 2, 0, 20);
    do_add(0, 0, 3, 0, 21);
    do_add(0, 0, 0, 0, 22);
    do_add(1, 0, 3, 0, 23);
    do_add(1, 0, 5, 0, 24);
    do_add(1, 0, 0, 0, 25);
    rewrite_i = 1; tick();
    chk("R9 upgrade rewritten", head_op_o, 1);
    chk("R9 head order", head_order_o, 20);
    pop_i = 1; add_i = 1; set_tgt(0, 0, 0, 26); tick();
    chk("R12 add+pop count", num_targets_o, 6);
    pop_expect("R9 sc rewritten / R12 head advanced", 21, 4, 0);
    pop_expect("R9 read kept", 22, 0, 0);
    pop_expect("R12 late add", 26, 0, 0);
    promote_i = 1; tick();
    wait_promo(bc);
    chk("R7 stops at maintenance (busy)", bc, 2);
    chk("R7 total after promote", num_targets_o, 3);
    pop_expect("R9 deferred rewritten", 23, 4, 1);
    chk("R7 maintenance not promoted", has_targets_o, 0);
    dealloc_i = 1; tick();
  endtask

  task automatic t_mask_full();
    do_alloc(2, 0, 0, 30);
    do_add(0, 0, 0, 0, 31);
    do_add(0, 1, 0, 0, 32);
    do_add(0, 0, 0, 0, 33);
    do_add(0, 1, 0, 0, 34);
    chk("R10 serviceable mask", serviceable_o, 8'h16);
    do_add(0, 2, 0, 0, 35);
    do_add(0, 2, 0, 0, 36);
    do_add(0, 2, 0, 0, 37);
    chk("R3 primary full count", num_targets_o, 8);
    add_i = 1; set_tgt(0, 0, 0, 38); #1;
    chk("R3 stall on full", stall_o, 1);
    tick();
    chk("R3 full add dropped", num_targets_o, 8);
    do_add(1, 0, 0, 0, 39);
    chk("R3 deferred add while primary full", num_targets_o, 9);
    dealloc_i = 1; tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    t_reset();
    t_main_flow();
    t_rewrite_promote();
    t_mask_full();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule